// File: doc/BRIEF.md
# Bounded-Delay Symbol Channel

This block models one direction of a point-to-point line between two nodes. A sender puts line symbols (request, acknowledge or idle) onto the line. The far side takes them off in order. The channel holds at most two different symbols in flight. Each symbol carries its own age, counted in ticks of a shared time strobe.

The oldest symbol is always shown at the output. When its age reaches the parameter `DELAY`, the channel raises a must-deliver flag and refuses to let time advance until the far side takes the symbol. A repeated send of the symbol already newest on the line is absorbed. A send that would need a third slot is illegal: it latches an error flag and changes nothing.

When a delivery, a send and a tick arrive in one cycle, they are applied in that order. Each one acts on the state the previous one left behind.

Top module: `chan_delay_line`

## Requirements
- R1: While rst_n is low and after its release, out_vld=0, out_sym=0, must_dlv=0 and err=0.
- R2: Symbol codes on snd_sym and out_sym are 1=request, 2=acknowledge, 3=idle. A send strobe with code 0 changes nothing.
- R3: A send into the empty channel makes out_vld=1 and out_sym equal to the sent code in the next cycle, and starts that symbol's age at 0.
- R4: A send of the code equal to the newest held symbol leaves the contents and the ages unchanged.
- R5: With one symbol held, a send of a different code appends it behind the first; out_sym keeps the first, and the new symbol's age starts at 0 and is tracked separately; after the first is delivered, the second is shown with its own age.
- R6: dlv with one symbol held empties the channel; dlv on an empty channel has no effect.
- R7: A tick adds one to the ages only when the channel holds a symbol and the oldest symbol's age is below DELAY; otherwise it changes nothing.
- R8: must_dlv is 1 exactly when a symbol is held and the oldest age equals DELAY; it remains 1 until a delivery.
- R9: With two symbols held, a send of any code other than the newest sets err, which stays 1 until reset, and leaves the contents unchanged.
- R10: In one cycle, dlv is applied first, the send is applied to the resulting state, and the tick is then applied to the state after the send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_vld | input | 1 | Send strobe |
| snd_sym | input | 2 | Code of the symbol being sent |
| tick | input | 1 | Time-step strobe |
| dlv | input | 1 | Far side takes the oldest symbol |
| out_vld | output | 1 | A symbol is held |
| out_sym | output | 2 | Code of the oldest held symbol, 0 when empty |
| must_dlv | output | 1 | Oldest symbol has reached the delay bound |
| err | output | 1 | Sticky illegal-send flag |

## Verification
Delivery and a send can land in the same cycle, and a tick can be added to them. The order of application then decides whether the send meets an empty channel, a single symbol or a pair. The bench drives these together from the pair state and from the single state, with a tick in the same cycle. It judges the result by the shown symbol, the error flag, and how many further ticks pass before must_dlv rises. A behavioural queue model, compared on every clock, covers the same collisions under random stimulus.

// File: rtl/chan_pkg.sv
`timescale 1ns/1ps
package chan_pkg;
   typedef enum logic [1:0] {
      SYM_NONE = 2'd0,
      SYM_REQ  = 2'd1,
      SYM_ACK  = 2'd2,
      SYM_IDLE = 2'd3
   } sym_e;

   localparam int unsigned SLOTS = 2;
   localparam int unsigned OCC_W = 2;
endpackage

// File: rtl/chan_age_ctr.sv
`timescale 1ns/1ps
module chan_age_ctr #(
   parameter int unsigned CW    = 6,
   parameter int unsigned LIMIT = 31
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic          inc,
   output logic [CW-1:0] q
);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   if (LIMIT >= (1 << CW)) begin : g_bad_width
      $error("chan_age_ctr: LIMIT does not fit in CW bits");
   end

   logic [CW-1:0] base;
   logic [CW-1:0] nxt;

   always_comb begin
      if (clr)     base = '0;
      else if (ld) base = ld_val;
      else         base = q;
      nxt = base;
      if (inc && (base < LIM_V)) nxt = base + CW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/chan_occ.sv
`timescale 1ns/1ps
module chan_occ
   import chan_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snd_vld,
   input  sym_e             snd_sym,
   input  logic             dlv,
   output logic [OCC_W-1:0] occ_q,
   output sym_e             head_q,
   output logic [OCC_W-1:0] post_occ,
   output logic             head_clr,
   output logic             head_shift,
   output logic             tail_clr,
   output logic             err_q
);
   sym_e             tail_q;
   sym_e             h_n, t_n;
   logic [OCC_W-1:0] c_n;
   logic             bad;
   logic             snd_real;

   assign snd_real = snd_vld && (snd_sym != SYM_NONE);

   always_comb begin
      c_n        = occ_q;
      h_n        = head_q;
      t_n        = tail_q;
      head_clr   = 1'b0;
      head_shift = 1'b0;
      tail_clr   = 1'b0;
      bad        = 1'b0;
      // step 1: delivery of the oldest symbol
      if (dlv && (occ_q != '0)) begin
         if (occ_q == OCC_W'(2)) begin
            h_n        = tail_q;
            t_n        = SYM_NONE;
            head_shift = 1'b1;
         end else begin
            h_n = SYM_NONE;
         end
         c_n = occ_q - OCC_W'(1);
      end
      // step 2: send applied to the post-delivery state
      if (snd_real) begin
         unique case (c_n)
            OCC_W'(0): begin
               h_n      = snd_sym;
               c_n      = OCC_W'(1);
               head_clr = 1'b1;
               tail_clr = 1'b1;
            end
            OCC_W'(1): begin
               if (snd_sym != h_n) begin
                  t_n      = snd_sym;
                  c_n      = OCC_W'(2);
                  tail_clr = 1'b1;
               end
            end
            default: begin
               if (snd_sym != t_n) bad = 1'b1;
            end
         endcase
      end
   end

   assign post_occ = c_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q  <= '0;
         head_q <= SYM_NONE;
         tail_q <= SYM_NONE;
         err_q  <= 1'b0;
      end else begin
         occ_q  <= c_n;
         head_q <= h_n;
         tail_q <= t_n;
         err_q  <= err_q | bad;
      end
   end
endmodule

// File: rtl/chan_delay_line.sv
`timescale 1ns/1ps
module chan_delay_line
   import chan_pkg::*;
#(
   parameter int unsigned DELAY = 30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       snd_vld,
   input  logic [1:0] snd_sym,
   input  logic       tick,
   input  logic       dlv,
   output logic       out_vld,
   output logic [1:0] out_sym,
   output logic       must_dlv,
   output logic       err
);
   localparam int unsigned SAT = DELAY + 1;
   localparam int unsigned CW  = $clog2(SAT + 1);
   localparam logic [CW-1:0] DLY_V = CW'(DELAY);

   if (DELAY < 1) begin : g_bad_delay
      $error("chan_delay_line: DELAY must be at least 1");
   end

   logic [OCC_W-1:0] occ_cnt;
   logic [OCC_W-1:0] post_occ;
   sym_e             head_sym;
   logic             head_clr, head_shift, tail_clr;
   logic             tick_ok;
   logic [CW-1:0]    age_q [SLOTS];
   logic [CW-1:0]    head_age;
   logic [CW-1:0]    post_head_age;
   logic             slot_clr [SLOTS];
   logic             slot_ld  [SLOTS];
   logic [CW-1:0]    slot_ldv [SLOTS];

   chan_occ u_occ (
      .clk        (clk),
      .rst_n      (rst_n),
      .snd_vld    (snd_vld),
      .snd_sym    (sym_e'(snd_sym)),
      .dlv        (dlv),
      .occ_q      (occ_cnt),
      .head_q     (head_sym),
      .post_occ   (post_occ),
      .head_clr   (head_clr),
      .head_shift (head_shift),
      .tail_clr   (tail_clr),
      .err_q      (err)
   );

   assign slot_clr[0] = head_clr;
   assign slot_ld[0]  = head_shift;
   assign slot_ldv[0] = age_q[1];
   assign slot_clr[1] = tail_clr;
   assign slot_ld[1]  = 1'b0;
   assign slot_ldv[1] = '0;

   for (genvar s = 0; s < SLOTS; s++) begin : g_age
      chan_age_ctr #(.CW(CW), .LIMIT(SAT)) u_ctr (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (slot_clr[s]),
         .ld     (slot_ld[s]),
         .ld_val (slot_ldv[s]),
         .inc    (tick_ok),
         .q      (age_q[s])
      );
   end

   assign head_age = age_q[0];

   always_comb begin
      if (head_clr)        post_head_age = '0;
      else if (head_shift) post_head_age = age_q[1];
      else                 post_head_age = age_q[0];
   end

   // step 3: time advances on the post-send state only below the bound
   assign tick_ok  = tick && (post_occ != '0) && (post_head_age < DLY_V);

   assign out_vld  = (occ_cnt != '0);
   assign out_sym  = head_sym;
   assign must_dlv = out_vld && (head_age == DLY_V);
endmodule

// File: rtl/chan_delay_line_chk.sv
`timescale 1ns/1ps
module chan_delay_line_chk #(
   parameter int unsigned DELAY = 30,
   parameter int unsigned CW    = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          snd_vld,
   input logic [1:0]    snd_sym,
   input logic          tick,
   input logic          dlv,
   input logic          out_vld,
   input logic [1:0]    out_sym,
   input logic          must_dlv,
   input logic          err,
   input logic [1:0]    occ,
   input logic [CW-1:0] head_age
);
   a_r3_send_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_vld && snd_vld && snd_sym != 2'd0) |=> (out_vld && out_sym == $past(snd_sym)));

   a_r2_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_vld && !(snd_vld && snd_sym != 2'd0)) |=> !out_vld);

   a_r4_repeat_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == 2'd1 && !dlv && snd_vld && snd_sym == out_sym) |=> (occ == 2'd1 && $stable(out_sym)));

   a_r5_pair_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == 2'd1 && !dlv && snd_vld && snd_sym != 2'd0 && snd_sym != out_sym)
      |=> (occ == 2'd2 && $stable(out_sym)));

   a_r6_last_delivery: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == 2'd1 && dlv && !(snd_vld && snd_sym != 2'd0)) |=> !out_vld);

   a_r8_hold_until_dlv: assert property (@(posedge clk) disable iff (!rst_n)
      (must_dlv && !dlv) |=> must_dlv);

   a_r7_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (head_age <= CW'(DELAY)));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
endmodule

bind chan_delay_line chan_delay_line_chk #(.DELAY(DELAY), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .snd_vld  (snd_vld),
   .snd_sym  (snd_sym),
   .tick     (tick),
   .dlv      (dlv),
   .out_vld  (out_vld),
   .out_sym  (out_sym),
   .must_dlv (must_dlv),
   .err      (err),
   .occ      (occ_cnt),
   .head_age (head_age)
);

// File: tb/tb_chan_delay_line.sv
`timescale 1ns/1ps
module tb_chan_delay_line;
   localparam int DLY = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       snd_vld = 1'b0;
   logic [1:0] snd_sym = 2'd0;
   logic       tick = 1'b0;
   logic       dlv = 1'b0;
   logic       out_vld, must_dlv, err;
   logic [1:0] out_sym;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 0;
   string cur_req = "R1";

   int m_sym[$];
   int m_age[$];
   bit m_err;

   always #4 clk = ~clk;

   chan_delay_line #(.DELAY(DLY)) dut (
      .clk(clk), .rst_n(rst_n), .snd_vld(snd_vld), .snd_sym(snd_sym),
      .tick(tick), .dlv(dlv), .out_vld(out_vld), .out_sym(out_sym),
      .must_dlv(must_dlv), .err(err)
   );

   task automatic chk(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_step(bit sv, int sym, bit tk, bit dv);
      if (dv && m_sym.size() > 0) begin
         void'(m_sym.pop_front());
         void'(m_age.pop_front());
      end
      if (sv && sym != 0) begin
         if (m_sym.size() == 0) begin
            m_sym.push_back(sym); m_age.push_back(0);
         end else if (sym == m_sym[m_sym.size()-1]) begin
         end else if (m_sym.size() == 1) begin
            m_sym.push_back(sym); m_age.push_back(0);
         end else begin
            m_err = 1;
         end
      end
      if (tk && m_sym.size() > 0 && m_age[0] < DLY)
         foreach (m_age[i]) m_age[i] = (m_age[i] + 1 > DLY + 1) ? DLY + 1 : m_age[i] + 1;
   endtask

   task automatic compare_model();
      int ev, es, em;
      ev = (m_sym.size() > 0);
      es = ev ? m_sym[0] : 0;
      em = ev && (m_age[0] == DLY);
      n_tests++;
      if (out_vld !== ev[0] || out_sym !== es[1:0] || must_dlv !== em[0] || err !== m_err) begin
         n_fail++;
         $display("FAIL %s: actual vld=%0d sym=%0d must=%0d err=%0d expected vld=%0d sym=%0d must=%0d err=%0d",
                  cur_req, out_vld, out_sym, must_dlv, err, ev, es, em, m_err);
      end
   endtask

   task automatic step(bit sv, int sym, bit tk, bit dv);
      snd_vld = sv; snd_sym = sym[1:0]; tick = tk; dlv = dv;
      @(posedge clk);
      model_step(sv, sym, tk, dv);
      #1;
      snd_vld = 0; snd_sym = 0; tick = 0; dlv = 0;
      @(negedge clk);
      compare_model();
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) step(0, 0, 1, 0);
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(negedge clk);
      m_sym.delete(); m_age.delete(); m_err = 0;
      rst_n = 1;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      rst_n = 0;
      repeat (2) @(negedge clk);
      chk("R1 vld in reset", out_vld, 0);
      do_reset();
      chk("R1 vld", out_vld, 0);
      chk("R1 sym", out_sym, 0);
      chk("R1 must", must_dlv, 0);
      chk("R1 err", err, 0);

      cur_req = "R7";
      ticks(3);
      chk("R7 empty tick", out_vld, 0);
      cur_req = "R6";
      step(0, 0, 0, 1);
      chk("R6 empty dlv", out_vld, 0);
      cur_req = "R2";
      step(1, 0, 0, 0);
      chk("R2 code zero", out_vld, 0);

      cur_req = "R3";
      step(1, 1, 0, 0);
      chk("R3 vld", out_vld, 1);
      chk("R3 sym", out_sym, 1);
      ticks(DLY - 1);
      chk("R8 below bound", must_dlv, 0);
      ticks(1);
      chk("R8 at bound", must_dlv, 1);
      cur_req = "R7";
      ticks(2);
      chk("R7 stalled", must_dlv, 1);
      cur_req = "R6";
      step(0, 0, 0, 1);
      chk("R6 emptied", out_vld, 0);

      cur_req = "R4";
      step(1, 2, 0, 0);
      ticks(3);
      step(1, 2, 0, 0);
      ticks(DLY - 4);
      chk("R4 age kept before", must_dlv, 0);
      ticks(1);
      chk("R4 age kept", must_dlv, 1);
      step(0, 0, 0, 1);

      cur_req = "R5";
      step(1, 3, 0, 0);
      ticks(2);
      step(1, 1, 0, 0);
      chk("R5 head kept", out_sym, 3);
      ticks(DLY - 2);
      chk("R5 head bound", must_dlv, 1);
      step(0, 0, 0, 1);
      chk("R5 second shown", out_sym, 1);
      chk("R5 second age", must_dlv, 0);
      ticks(2);
      chk("R5 second bound", must_dlv, 1);
      step(0, 0, 0, 1);
      chk("R6 after pair", out_vld, 0);

      cur_req = "R10";
      step(1, 2, 0, 0);
      step(1, 3, 0, 0);
      step(1, 1, 1, 1);
      chk("R10 pair dlv+snd sym", out_sym, 3);
      chk("R10 pair dlv+snd err", err, 0);
      step(0, 0, 0, 1);
      chk("R10 tail sym", out_sym, 1);
      ticks(DLY - 2);
      chk("R10 tail age", must_dlv, 0);
      ticks(1);
      chk("R10 tail bound", must_dlv, 1);
      step(1, 2, 1, 1);
      chk("R10 single dlv+snd sym", out_sym, 2);
      ticks(DLY - 2);
      chk("R10 fresh age", must_dlv, 0);
      ticks(1);
      chk("R10 fresh bound", must_dlv, 1);
      step(0, 0, 0, 1);

      cur_req = "R9";
      step(1, 1, 0, 0);
      step(1, 2, 0, 0);
      step(1, 3, 0, 0);
      chk("R9 err set", err, 1);
      chk("R9 head kept", out_sym, 1);
      step(1, 1, 0, 0);
      step(0, 0, 0, 1);
      chk("R9 tail kept", out_sym, 2);
      step(0, 0, 0, 1);
      chk("R9 not added", out_vld, 0);
      chk("R9 sticky", err, 1);

      do_reset();
      chk("R1 err cleared", err, 0);

      cur_req = "R10 random";
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         step(r < 30, $urandom_range(0, 3), $urandom_range(0, 1), (r % 4) == 0);
         if (m_err) do_reset();
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule